// File: doc/BRIEF.md
# Discrete-log code to integer converter

This block turns a k-bit discrete-log codeword into the ordinary unsigned binary integer it encodes, modulo 2^k. The codeword is read from its low end. A run of zeros ends at the first set bit, called the marker, and the length of that run is the power-of-two exponent p. The bit just above the marker is a separation bit. All the bits above the separation bit form the exponent e. The sign s is the separation bit XORed with the lowest bit of e. The value returned is (-1)^s · 2^p · 3^e mod 2^k. A codeword of all zeros returns zero.

The block computes 3^e with one shared multiplier. It walks the bits of e from the least significant end: on each step it squares the running base, and it multiplies the base into the accumulator when the current bit of e is set. It ends as soon as no set bit of e remains. The accumulator is then shifted left by p and negated in two's complement when s is 1.

A caller pulses `start` with a codeword while the block is idle. It then waits for the one-cycle `done` pulse. `result` keeps its value until a later accepted request finishes.

Top module: `dlog_to_int`

## Requirements
- R1: An all-zero codeword produces result 0.
- R2: For a non-zero codeword whose lowest set bit is at position p, bits p-1..0 of the result are 0 and bit p of the result is 1.
- R3: The sign equals the bit at position p+1 XORed with the lowest bit of e. When the sign is 1, the result is the two's complement, mod 2^W, of 2^p·3^e.
- R4: A codeword whose only set bit is the top bit W-1 produces exactly 2^(W-1).
- R5: When p = W-2, e is 0 and the sign is bit W-1 of the codeword. For W=5, codeword 01000 gives 8 and codeword 11000 gives 24.
- R6: For every codeword, result = (-1)^s·2^p·3^e mod 2^W, where e is the codeword shifted right by p+2. For W=5 this covers all 32 codes; for example 10110 gives 14 and 10101 gives 13.
- R7: A start pulse while busy is high is ignored. The request in progress completes with its own result.
- R8: done is high for exactly one cycle per accepted request. result does not change while the block is idle.
- R9: busy rises on the clock edge that accepts start. busy falls on the edge where done rises.
- R10: After reset, busy, done and result are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; accepted only while idle |
| code | input | W | Discrete-log codeword, sampled when start is accepted |
| busy | output | 1 | High while a conversion is in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | W | Binary integer, held until the next completion |

## Verification
The assertions do not require `code` to be stable after the accepting edge, since the block keeps its own copy. They do require reset to be applied once before the first request. The properties on the result (exactly p trailing zeros, zero for an empty code) are stated against the copy the block took at acceptance. So a start pulse that arrives while busy, carrying a different code, must leave that copy unchanged; the bench deliberately sends such pulses. All stimulus changes on the falling clock edge, and each new request is issued only after the previous `done`, except in the case that probes R7.

// File: rtl/dlog_to_int.sv
module dlog_to_int #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] code,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int PW = $clog2(W);
  localparam int EW = W - 2;

  logic [PW-1:0] tz;
  always_comb begin
    tz = '0;
    for (int i = W - 1; i >= 0; i--)
      if (code[i]) tz = PW'(i);
  end

  logic [W-1:0]  above;
  logic [EW-1:0] e_in;
  logic          s_in;
  assign above = W'(code >> (32'(tz) + 1));
  assign e_in  = EW'(code >> (32'(tz) + 2));
  assign s_in  = above[0] ^ e_in[0];

  logic [PW-1:0] p_q;
  logic          s_q, zero_q;
  logic [EW-1:0] e_q;
  logic [W-1:0]  acc, base;

  logic [W-1:0] shifted, fin;
  assign shifted = acc << p_q;
  assign fin = zero_q ? '0 : (s_q ? W'(0) - shifted : shifted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      p_q    <= '0;
      s_q    <= 1'b0;
      zero_q <= 1'b0;
      e_q    <= '0;
      acc    <= '0;
      base   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          p_q    <= tz;
          s_q    <= s_in;
          zero_q <= (code == '0);
          e_q    <= e_in;
          acc    <= W'(1);
          base   <= W'(3);
        end
      end else if (e_q == '0) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= fin;
      end else begin
        if (e_q[0]) acc <= acc * base;
        base <= base * base;
        e_q  <= e_q >> 1;
      end
    end
  end

  logic [W-1:0] low_mask;
  assign low_mask = (W'(1) << p_q) - W'(1);

  assert_zero_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done && zero_q |-> result == '0);

  assert_trailing_zeros_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !zero_q |-> ((result & low_mask) == '0) && result[p_q]);

  assert_busy_ignores_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(p_q) && $stable(s_q) && $stable(zero_q));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));

  assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && e_q == '0 |=> done && !busy);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

// File: tb/dlog_to_int_test.sv
module dlog_to_int_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  localparam logic [4:0] K5_MAP [32] = '{
    5'd0,  5'd1,  5'd2,  5'd31, 5'd4,  5'd29, 5'd30, 5'd3,
    5'd8,  5'd9,  5'd26, 5'd23, 5'd28, 5'd5,  5'd6,  5'd27,
    5'd16, 5'd17, 5'd18, 5'd15, 5'd20, 5'd13, 5'd14, 5'd19,
    5'd24, 5'd25, 5'd10, 5'd7,  5'd12, 5'd21, 5'd22, 5'd11
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start5 = 1'b0;
  logic [W-1:0] code = '0;
  logic [4:0] code5 = '0;
  logic busy, done, busy5, done5;
  logic [W-1:0] result;
  logic [4:0] result5;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycles++;

  dlog_to_int #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code),
    .busy(busy), .done(done), .result(result));

  dlog_to_int #(.W(5)) uut_k5 (
    .clk(clk), .rst_n(rst_n), .start(start5), .code(code5),
    .busy(busy5), .done(done5), .result(result5));

  function automatic logic [W-1:0] ref16(input logic [W-1:0] c);
    int p;
    logic sep, s;
    logic [W-1:0] e, v;
    if (c == '0) return '0;
    p = 0;
    while (!c[p]) p++;
    sep = (p <= W - 2) ? c[p+1] : 1'b0;
    e = c >> (p + 2);
    s = sep ^ e[0];
    v = 1;
    for (int k = 0; k < int'(e); k++) v = v * 3;
    v = v << p;
    return s ? W'(0) - v : v;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_done16();
    int n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic run16(input logic [W-1:0] c, input string req);
    @(negedge clk);
    code = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done16();
    check(req, result, ref16(c));
  endtask

  task automatic run5(input logic [4:0] c);
    int n = 0;
    @(negedge clk);
    code5 = c; start5 = 1'b1;
    @(negedge clk);
    start5 = 1'b0;
    while (!done5 && n < 100) begin @(negedge clk); n++; end
    check("R6 k5", W'(result5), W'(K5_MAP[c]));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] lfsr, held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 busy", W'(busy), '0);
    check("R10 done", W'(done), '0);
    check("R10 result", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 32; i++) run5(5'(i));

    run16(16'h0000, "R1");
    check("R1 zero", result, '0);
    run16(16'h8000, "R4");
    check("R4 top", result, 16'h8000);
    run16(16'h4000, "R5 sep0");
    check("R5 sep0", result, 16'h4000);
    run16(16'hC000, "R5 sep1");
    check("R5 sep1", result, 16'hC000);
    run16(16'h0001, "R6");
    run16(16'h0003, "R3");
    check("R3 minus1", result, 16'hFFFF);
    run16(16'hFFFF, "R6");
    run16(16'hFFFE, "R2");
    check("R2 bit", W'(result[1]), 16'd1);
    run16(16'h2000, "R6");
    run16(16'h00A0, "R2");
    lfsr = 16'hACE1;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run16(lfsr, "R6 sweep");
    end

    // R9 busy after accept, R7 start ignored while busy
    @(negedge clk);
    code = 16'hFFFD; start = 1'b1;
    @(negedge clk);
    check("R9 busy", W'(busy), 16'd1);
    code = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done16();
    check("R7 ignored", result, ref16(16'hFFFD));
    check("R9 idle at done", W'(busy), '0);
    held = result;
    @(negedge clk);
    check("R8 pulse", W'(done), '0);
    code = 16'h1234;
    repeat (3) @(negedge clk);
    check("R8 hold", result, held);
    finish_run();
  end
endmodule